// File: doc/BRIEF.md
# External Interrupt Aggregator

This block collects a set of asynchronous external interrupt lines and presents them to a parent interrupt controller as one combined request. Each line is brought into the local clock domain by a two-flop synchroniser. A rising edge on the synchronised line sets a sticky pending bit for that source. Every source also has its own mask bit and its own clear bit, and the request output is high whenever at least one pending source is unmasked.

Software reaches the block through a single-cycle 32-bit register port with an address, a write enable, write data and combinational read data. There are three registers. The pending-status register at offset 0x1c is read-only and shows every source, masked or not. The mask register at offset 0x14 blocks a source when its bit is 1. The clear register at offset 0x10 acknowledges a source. To clear a source, software writes its clear bit to 1 and then writes it back to 0. While the clear bit is 1 the pending bit stays at 0, and capture starts again once the clear bit returns to 0. Software normally reads the status register and services the set bits from the lowest-numbered one upward, acknowledging each in turn. The parent treats the combined output as a level request.

Top module: `ext_irq_aggregator`

## Requirements
- R1: After reset every pending bit and every clear bit is 0, every mask bit is 1, and `irq_o` is 0.
- R2: When source i rises, bit i of the status register (offset 0x1c) reads 1 after the third rising clock edge. It still reads 0 after the second edge.
- R3: A pending bit is sticky. It is set once for a source held high, and it stays set after the source falls, until it is cleared.
- R4: While bit i of the clear register (offset 0x10) is 1, pending bit i reads 0 from the next clock edge onward. A rising edge of source i that arrives during that time is discarded.
- R5: After the clear bit returns to 0, a source that stays high does not set its pending bit again. A later rising edge sets it normally.
- R6: Bit i of the mask register (offset 0x14) blocks source i when 1 and passes it when 0. `irq_o` is registered: it equals the OR over all sources of (pending AND NOT mask) one clock edge after those values hold.
- R7: The status register returns the raw pending bits whatever the mask holds.
- R8: The clear and mask registers read back exactly the 32 bits last written to them.
- R9: Writes to the status offset and to any unused offset change no register. Reads of unused offsets return 0.
- R10: With several sources pending, the status register shows all of them at once. `irq_o` stays high while software clears them lowest bit first, and falls only after the last unmasked pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | External interrupt lines, asynchronous |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
The bench builds the block with its default of 32 sources and an 8-bit offset, so it can sweep every source number one at a time. For each source it measures the exact capture latency, the effect of the mask, clearing, discarding an edge that arrives while the clear bit is held, and recapture. A mixed multi-source pattern then covers reading status with sources masked, servicing the bits lowest first, and writes to the status offset and to offsets that decode to nothing.

// File: rtl/eia_pkg.sv
// Package: shared constants and the offset decode for the aggregator.
// Assumes byte offsets fit in 8 bits and registers are 32 bits wide.
package eia_pkg;
    localparam int unsigned REG_W    = 32;
    localparam logic [7:0]  OFS_CLR  = 8'h10;
    localparam logic [7:0]  OFS_MASK = 8'h14;
    localparam logic [7:0]  OFS_STAT = 8'h1c;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CLR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    // Map a byte offset onto the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_CLR:  decode_ofs = SEL_CLR;
            OFS_MASK: decode_ofs = SEL_MASK;
            OFS_STAT: decode_ofs = SEL_STAT;
            default:  decode_ofs = SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/eia_sync.sv
// Module: eia_sync
// Two-flop synchroniser, one chain per source line.
// Assumes the source lines are asynchronous and stay high or low for at
// least two clock periods.
module eia_sync #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] async_i,
    output logic [NUM_SRC-1:0] sync_o
);
    logic [NUM_SRC-1:0] stage1_q;
    logic [NUM_SRC-1:0] stage2_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        // Two-stage capture of one asynchronous line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[g] <= 1'b0;
                stage2_q[g] <= 1'b0;
            end else begin
                stage1_q[g] <= async_i[g];
                stage2_q[g] <= stage1_q[g];
            end
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/eia_capture.sv
// Module: eia_capture
// Detects rising edges of the synchronised lines and keeps a sticky pending
// bit per source. A clear bit at 1 holds its pending bit at 0, and an edge
// that arrives in that window is discarded.
// Assumes sync_i is already in the clk domain.
module eia_capture #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] rise;

    assign rise = sync_i & ~prev_q;

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    // Set pending on an edge, hold it while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | rise) & ~clr_i;
    end

    assign pend_o = pend_q;

    // R4: a held clear forces its pending bit low on the next edge.
    assert_clear_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0));

    // R3: a pending bit falls only where the clear bit was set.
    assert_sticky_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));

    // R2: an edge outside a clear window always sets its pending bit.
    assert_edge_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~clr_i) != '0) |=> ((pend_q & $past(rise & ~clr_i)) == $past(rise & ~clr_i)));
endmodule

// File: rtl/eia_regs.sv
// Module: eia_regs
// Register port: stores the clear and mask registers, decodes writes and
// drives combinational read data. The status offset is read-only.
// Assumes NUM_SRC <= 32 and one write per cycle at most.
module eia_regs
    import eia_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [REG_W-1:0]   rd_data_o
);
    logic [NUM_SRC-1:0] clr_q;
    logic [NUM_SRC-1:0] mask_q;
    reg_sel_e           sel;

    assign sel = decode_ofs(8'(addr_i));

    // Clear register: written by software, held until rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n)                          clr_q <= '0;
        else if (wr_en_i && sel == SEL_CLR)  clr_q <= wr_data_i[NUM_SRC-1:0];
    end

    // Mask register: every source masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '1;
        else if (wr_en_i && sel == SEL_MASK) mask_q <= wr_data_i[NUM_SRC-1:0];
    end

    // Read multiplexer; unused offsets return zero.
    always_comb begin
        case (sel)
            SEL_CLR:  rd_data_o = REG_W'(clr_q);
            SEL_MASK: rd_data_o = REG_W'(mask_q);
            SEL_STAT: rd_data_o = REG_W'(pend_i);
            default:  rd_data_o = '0;
        endcase
    end

    assign clr_o  = clr_q;
    assign mask_o = mask_q;

    // R1: reset leaves all sources masked and no clear held.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && clr_q == '0));

    // R9: a write that selects no writable register changes nothing.
    assert_nowrite_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel != SEL_CLR && sel != SEL_MASK) |=> ($stable(mask_q) && $stable(clr_q)));
endmodule

// File: rtl/ext_irq_aggregator.sv
// Module: ext_irq_aggregator (top)
// Merges NUM_SRC external interrupt lines into one registered request for a
// parent controller, with per-source mask, clear and pending status.
// Assumes a single-cycle register access and NUM_SRC <= 32.
module ext_irq_aggregator
    import eia_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] mask;
    logic               irq_q;

    eia_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    eia_capture #(.NUM_SRC(NUM_SRC)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (src_sync),
        .clr_i  (clr),
        .pend_o (pend)
    );

    eia_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .pend_i    (pend),
        .clr_o     (clr),
        .mask_o    (mask),
        .rd_data_o (rd_data_o)
    );

    // Registered OR of unmasked pending sources, glitch-free to the parent.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend & ~mask);
    end

    assign irq_o = irq_q;

    // R6: an unmasked pending source raises the request one edge later.
    assert_irq_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) != '0) |=> irq_o);

    // R6: with nothing unmasked and pending, the request drops one edge later.
    assert_irq_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) == '0) |=> !irq_o);
endmodule

// File: tb/ext_irq_aggregator_test.sv
`timescale 1ns/1ps
module ext_irq_aggregator_test;
    localparam int unsigned N = 32;
    localparam logic [7:0] A_CLR  = 8'h10;
    localparam logic [7:0] A_MASK = 8'h14;
    localparam logic [7:0] A_STAT = 8'h1c;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ext_irq_aggregator #(.NUM_SRC(N), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Write at one edge; returns at the following negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        logic [31:0] left;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(A_CLR, v);  chk("R1 clear", v, 32'h0);
        rd(A_MASK, v); chk("R1 mask", v, 32'hffff_ffff);
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < N; i++) begin
            logic [31:0] b;
            b = 32'h1 << i;
            src[i] = 1'b1;
            cyc(2);
            rd(A_STAT, v); chk("R2 not yet after two edges", v, 32'h0);
            cyc(1);
            rd(A_STAT, v); chk("R2 set after third edge", v, b);
            cyc(2);
            chk("R6 masked source silent", {31'b0, irq}, 32'h0);
            wr(A_MASK, ~b);
            chk("R6 irq one edge after unmask", {31'b0, irq}, 32'h0);
            cyc(1);
            chk("R6 irq raised", {31'b0, irq}, 32'h1);
            src[i] = 1'b0;
            cyc(3);
            rd(A_STAT, v); chk("R3 sticky after fall", v, b);
            wr(A_CLR, b);
            cyc(1);
            rd(A_STAT, v); chk("R4 cleared", v, 32'h0);
            rd(A_CLR, v);  chk("R8 clear readback", v, b);
            cyc(1);
            chk("R6 irq low after clear", {31'b0, irq}, 32'h0);
            src[i] = 1'b1;
            cyc(5);
            rd(A_STAT, v); chk("R4 edge during clear lost", v, 32'h0);
            wr(A_CLR, 32'h0);
            cyc(3);
            rd(A_STAT, v); chk("R5 held level not recaptured", v, 32'h0);
            src[i] = 1'b0;
            cyc(3);
            src[i] = 1'b1;
            cyc(3);
            rd(A_STAT, v); chk("R5 new edge recaptured", v, b);
            wr(A_CLR, b);
            src[i] = 1'b0;
            wr(A_CLR, 32'h0);
            wr(A_MASK, 32'hffff_ffff);
            cyc(3);
            rd(A_STAT, v); chk("R4 final clear", v, 32'h0);
        end

        // R7 raw status while everything masked
        pat = 32'hA5A5_0F0F;
        src = pat;
        cyc(5);
        rd(A_STAT, v); chk("R7 raw status masked", v, pat);
        chk("R7 irq stays low", {31'b0, irq}, 32'h0);

        // R9 writes to status and unused offsets
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R9 status write ignored", v, pat);
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h0);
        wr(8'h20, 32'hffff_ffff);
        rd(8'h00, v); chk("R9 unused 0x00 reads zero", v, 32'h0);
        rd(8'h18, v); chk("R9 unused 0x18 reads zero", v, 32'h0);
        rd(8'h20, v); chk("R9 unused 0x20 reads zero", v, 32'h0);
        rd(A_MASK, v); chk("R9 mask untouched", v, 32'hffff_ffff);
        rd(A_CLR, v);  chk("R9 clear untouched", v, 32'h0);

        // R8 mask readback
        wr(A_MASK, 32'h1234_5678);
        rd(A_MASK, v); chk("R8 mask readback", v, 32'h1234_5678);

        // R10 lowest-first service with all sources enabled
        wr(A_MASK, 32'h0);
        cyc(1);
        chk("R10 irq with many pending", {31'b0, irq}, 32'h1);
        left = pat;
        while (left != 0) begin
            logic [31:0] low;
            low = left & (~left + 32'h1);
            rd(A_STAT, v); chk("R10 status vector", v, left);
            wr(A_CLR, low);
            wr(A_CLR, 32'h0);
            left = left & ~low;
            cyc(1);
            chk("R10 irq while servicing", {31'b0, irq}, {31'b0, (left != 0)});
        end
        rd(A_STAT, v); chk("R10 all serviced", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule